// File: doc/BRIEF.md
# Private Countdown Timer with Prescaler

A per-core 32-bit down-counter behind a small word-addressed register bus. Software programs a reload value, optionally writes the live count directly, and sets a control word that enables counting, selects auto-reload, enables the interrupt and picks a prescale exponent. While enabled, the count drops by one every 16^prescale clock cycles. When it steps from one to zero the block records a raw event flag and, if the interrupt is enabled, a pending flag that drives the interrupt output.

All accesses are full 32-bit words. Reads are combinational on the address. A write takes effect at the rising clock edge where `wr_en` is high. The zero event either reloads the count or leaves it parked at zero. Any write to the status word clears both flags.

Top module: `prv_countdown_timer`

## Requirements
- R1: After reset the reload, count, control and status words all read 0, and `irq` is low.
- R2: A write to word offset 0x00 stores the reload value. If the timer is enabled, the same edge also sets the count to that value and restarts the prescaler. If the timer is disabled, the count is left unchanged.
- R3: A write to word offset 0x04 sets the count to the written value and restarts the prescaler, whether the timer is enabled or not.
- R4: A write to word offset 0x08 loads the control fields: bit 0 enable, bit 1 auto-reload, bit 2 interrupt enable, bits 15:8 prescale exponent. If it changes enable from 0 to 1, the count takes the stored reload value. A write that leaves enable at 1 does not reload the count.
- R5: While enabled and nonzero, the count decrements once every 16^p cycles after a restart. p is the prescale exponent, clamped to PSC_MAX (3 by default). An exponent of 200 therefore gives a period of 4096 cycles.
- R6: When the count steps from 1 to 0, status bit 0 (the raw flag) sets. The pending flag, visible as `irq`, sets only if interrupt enable is 1.
- R7: At that zero step the count takes the reload value if auto-reload is set. Otherwise it stays at 0 and no further events occur.
- R8: Any write to word offset 0x0C clears both the raw and pending flags, whatever the data. A zero event in the same cycle wins.
- R9: While disabled, the count does not change except through direct writes (R3), and no zero event occurs.
- R10: Control reads return the fields at the R4 positions with all other bits 0. Status reads return only the raw flag in bit 0. Addresses at or above 0x10 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | 8 | Byte address, word aligned |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq | output | 1 | Pending interrupt, high until cleared |

## Verification
The count is exercised with the prescale exponent at 0, at 1 and at a large value that must clamp. These cases separate a wrong decrement period from a wrong clamp. One-shot runs are contrasted with auto-reload runs, and runs with the interrupt enabled with runs where it is disabled, to show that the raw and pending flags set independently. Control writes that do and do not raise enable tell a reload on the rising edge apart from a reload on every write. A long phase of random writes to all words, compared every cycle against a behavioural model, covers collisions between writes and zero events.

// File: rtl/prv_countdown_timer.sv
module prv_countdown_timer #(
  parameter int DW      = 32,
  parameter int AW      = 8,
  parameter int PSC_W   = 8,
  parameter int PSC_MAX = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int PW = 4 * PSC_MAX;
  localparam logic [1:0] A_LOAD = 2'd0, A_CNT = 2'd1, A_CTRL = 2'd2, A_STAT = 2'd3;

  logic [DW-1:0]    load_q, cnt_q;
  logic             en_q, ar_q, ie_q, raw_q, pend_q;
  logic [PSC_W-1:0] psc_q, psc_eff;
  logic [PW-1:0]    pre_q, mask;

  wire       in_map  = (addr >> 4) == '0;
  wire [1:0] sel     = addr[3:2];
  wire       wr_load = wr_en && in_map && sel == A_LOAD;
  wire       wr_cnt  = wr_en && in_map && sel == A_CNT;
  wire       wr_ctrl = wr_en && in_map && sel == A_CTRL;
  wire       wr_stat = wr_en && in_map && sel == A_STAT;
  wire       en_rise = wr_ctrl && !en_q && wdata[0];
  wire       restart = (wr_load && en_q) || wr_cnt || en_rise;

  assign psc_eff = (psc_q > PSC_W'(PSC_MAX)) ? PSC_W'(PSC_MAX) : psc_q;
  assign mask    = {PW{1'b1}} >> (PW - 4 * int'(psc_eff));

  wire presc_hit = (pre_q & mask) == mask;
  wire tick      = en_q && presc_hit && cnt_q != '0 && !restart;
  wire zero_evt  = tick && cnt_q == DW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (restart) begin
      pre_q <= '0;
    end else if (en_q) begin
      pre_q <= presc_hit ? '0 : pre_q + PW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_load) load_q <= wdata;
      if (wr_load && en_q)  cnt_q <= wdata;
      else if (wr_cnt)      cnt_q <= wdata;
      else if (en_rise)     cnt_q <= load_q;
      else if (zero_evt)    cnt_q <= ar_q ? load_q : '0;
      else if (tick)        cnt_q <= cnt_q - DW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {en_q, ar_q, ie_q} <= '0;
      psc_q  <= '0;
      raw_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= wdata[0];
        ar_q  <= wdata[1];
        ie_q  <= wdata[2];
        psc_q <= wdata[8 +: PSC_W];
      end
      raw_q  <= zero_evt | (raw_q & !wr_stat);
      pend_q <= (zero_evt & ie_q) | (pend_q & !wr_stat);
    end
  end

  always_comb begin
    rdata = '0;
    if (in_map) begin
      case (sel)
        A_LOAD:  rdata = load_q;
        A_CNT:   rdata = cnt_q;
        A_CTRL:  begin
                   rdata[0] = en_q;
                   rdata[1] = ar_q;
                   rdata[2] = ie_q;
                   rdata[8 +: PSC_W] = psc_q;
                 end
        default: rdata[0] = raw_q;
      endcase
    end
  end

  assign irq = pend_q;

  p_load_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_load && en_q) |=> cnt_q == $past(wdata));
  p_cnt_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt_q == $past(wdata));
  p_enable_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> cnt_q == $past(load_q));
  p_pend_needs_raw_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> raw_q);
  p_pend_needs_ie_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !ie_q) |=> !pend_q);
  p_stop_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !wr_cnt && !(wr_load && en_q) && !en_rise) |=> cnt_q == '0);
  p_stat_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !zero_evt) |=> !raw_q && !irq);
  p_hold_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_cnt && !en_rise) |=> $stable(cnt_q));
endmodule

// File: tb/sim_prv_countdown_timer.sv
module sim_prv_countdown_timer;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        irq;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  prv_countdown_timer u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                          .wdata(wdata), .rdata(rdata), .irq(irq));

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference model
  logic [31:0] m_load, m_cnt;
  logic        m_en, m_ar, m_ie, m_raw, m_pend;
  logic [7:0]  m_psc;
  int          m_ph;
  bit          rs, hit, tk, ze;
  int          per;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_load = 0; m_cnt = 0; m_en = 0; m_ar = 0; m_ie = 0;
      m_raw = 0; m_pend = 0; m_psc = 0; m_ph = 0;
    end else begin
      rs  = wr_en && addr < 16 && ((addr[3:2] == 0 && m_en) || addr[3:2] == 1 ||
            (addr[3:2] == 2 && !m_en && wdata[0]));
      per = 16 ** ((m_psc > 3) ? 3 : int'(m_psc));
      hit = (m_ph % per) == per - 1;
      tk  = m_en && hit && m_cnt != 0 && !rs;
      ze  = tk && m_cnt == 1;
      if (rs) m_ph = 0;
      else if (m_en) m_ph = hit ? 0 : (m_ph + 1) % 4096;
      if (wr_en && addr < 16 && addr[3:2] == 0) begin
        if (m_en) m_cnt = wdata;
        m_load = wdata;
      end else if (wr_en && addr < 16 && addr[3:2] == 1) m_cnt = wdata;
      else if (rs) m_cnt = m_load;
      else if (ze) m_cnt = m_ar ? m_load : 0;
      else if (tk) m_cnt = m_cnt - 1;
      if (wr_en && addr < 16 && addr[3:2] == 3) begin m_raw = 0; m_pend = 0; end
      if (ze) begin m_raw = 1; if (m_ie) m_pend = 1; end
      if (wr_en && addr < 16 && addr[3:2] == 2) begin
        m_en = wdata[0]; m_ar = wdata[1]; m_ie = wdata[2]; m_psc = wdata[15:8];
      end
    end
  end

  function automatic logic [31:0] m_read(logic [7:0] a);
    if (a >= 16) return 0;
    case (a[3:2])
      0: return m_load;
      1: return m_cnt;
      2: return {16'b0, m_psc, 5'b0, m_ie, m_ar, m_en};
      default: return {31'b0, m_raw};
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check("R10 model readback", rdata, m_read(addr));
    check("R6 model irq", {31'b0, irq}, {31'b0, m_pend});
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(string req, logic [7:0] a, logic [31:0] exp);
    addr = a;
    @(negedge clk);
    check(req, rdata, exp);
  endtask

  task automatic wait_edges(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    // R1 reset state
    rd("R1 load", 8'h00, 0); rd("R1 count", 8'h04, 0);
    rd("R1 ctrl", 8'h08, 0); rd("R1 status", 8'h0C, 0);
    check("R1 irq", {31'b0, irq}, 0);
    // R2 load while disabled leaves count
    wr(8'h00, 5);
    rd("R2 load stored", 8'h00, 5); rd("R2 disabled no restart", 8'h04, 0);
    // R3 / R9 direct count write while disabled holds
    wr(8'h04, 7);
    rd("R3 count written", 8'h04, 7);
    wait_edges(10);
    rd("R9 disabled holds", 8'h04, 7);
    // R4 enable rise reloads; R6 event with ie
    wr(8'h08, 32'h5);
    rd("R4 enable reloads", 8'h04, 5);
    wait_edges(4);
    rd("R6 not yet zero", 8'h04, 1);
    check("R6 irq low before zero", {31'b0, irq}, 0);
    wait_edges(1);
    rd("R6 raw set", 8'h0C, 1);
    check("R6 irq on zero", {31'b0, irq}, 1);
    wait_edges(20);
    rd("R7 one-shot stays zero", 8'h04, 0);
    // R8 clear with zero data
    wr(8'h0C, 0);
    rd("R8 raw cleared", 8'h0C, 0);
    check("R8 irq cleared", {31'b0, irq}, 0);
    // R6/R7 no ie, auto-reload
    wr(8'h08, 0); wr(8'h00, 2); wr(8'h08, 32'h3);
    rd("R4 reload 2", 8'h04, 2);
    wait_edges(2);
    rd("R7 auto-reload", 8'h04, 2);
    rd("R6 raw without ie", 8'h0C, 1);
    check("R6 no irq without ie", {31'b0, irq}, 0);
    // R4 no reload when enable stays set (tick in write cycle)
    wr(8'h08, 32'h3);
    rd("R4 no reload on held enable", 8'h04, 1);
    // R2 load while enabled restarts
    wr(8'h00, 9);
    rd("R2 enabled restart", 8'h04, 9);
    // R3 count write while enabled
    wr(8'h04, 3);
    rd("R3 enabled count write", 8'h04, 3);
    // R5 prescale 1
    wr(8'h08, 0); wr(8'h08, 32'h0101);
    rd("R5 reload p1", 8'h04, 9);
    wait_edges(15);
    rd("R5 p1 before period", 8'h04, 9);
    wait_edges(1);
    rd("R5 p1 after period", 8'h04, 8);
    // R5 clamp
    wr(8'h08, 0); wr(8'h08, 32'hC801);
    wait_edges(4095);
    rd("R5 clamp before period", 8'h04, 9);
    wait_edges(1);
    rd("R5 clamp after period", 8'h04, 8);
    // R10 field layout
    wr(8'h08, 32'hFFFF_FFF8);
    rd("R10 ctrl reserved bits", 8'h08, 32'h0000_FF00);
    rd("R10 unmapped", 8'h10, 0);
    wr(8'h0C, 32'hFFFF_FFFF);
    // random traffic, model compared each cycle
    for (int i = 0; i < 3000; i++) begin
      int k = int'($urandom_range(0, 9));
      if (k < 4) begin
        logic [7:0]  a = {4'b0, 2'($urandom_range(0, 3)), 2'b0};
        logic [31:0] d = (a == 8'h08) ? ($urandom & 32'h0000_0107) : 32'($urandom_range(0, 12));
        wr(a, d);
      end else begin
        addr = {4'b0, 2'($urandom_range(0, 3)), 2'b0};
        wait_edges(1);
      end
    end
    finish_run();
  end
endmodule